// File: doc/BRIEF.md
# Sampled Proportional-Integral Speed Controller

This block closes a motor speed loop in fixed point. A programmable down-counter produces a sample tick every `period_cyc` clock cycles. On each tick the block takes a signed speed command and subtracts a signed speed feedback. The feedback arrives as an unsigned magnitude plus a direction bit. The block then scales the difference by a gain of G/255 for an 8-bit G and rounds the result.

With integration enabled, the scaled error is added to the previous drive. With integration disabled, the scaled error is the drive. The drive is held to the signed 8-bit range. It is then offset by 0x80 so that zero drive sits at mid-scale of an unsigned 8-bit DAC word, and it is presented with a one-cycle valid strobe.

The accumulator stores the already-limited drive, so the integrator cannot wind beyond the DAC limits. The sample period is given in clock cycles: for a 4 ms loop at 200 MHz it is 800000.

Top module: `spd_pi_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_out` is 0x80 and `dac_valid` is 0. The first result after reset does not depend on any drive stored before reset.
- R2: The first sample tick occurs in the first clock cycle after reset is released. Later ticks follow every `period_cyc` cycles, and a `period_cyc` of 0 behaves as 1.
- R3: `dac_valid` is high for exactly the cycle after each tick, and `dac_out` changes only in a cycle where `dac_valid` is high.
- R4: The error is `cmd - f`. Here `f = +fb_mag` when `fb_dir` is 1 (forward) and `f = -fb_mag` when `fb_dir` is 0 (reverse).
- R5: The scaled error is error·gain/255 rounded to the nearest integer. Rounding is symmetric about zero, so a negative product rounds by its magnitude (for example 128/255 gives 1 and -128/255 gives -1).
- R6: With `integ_en` = 0, the drive equals the scaled error.
- R7: With `integ_en` = 1, the drive equals the scaled error plus the previous drive.
- R8: The drive is limited to the range -128..127 before it is stored. `dac_out` equals drive + 128. The stored drive is the limited value, so a later opposite error acts from the limit at once.
- R9: A gain of 0 gives `dac_out` = 0x80 with `integ_en` = 0, and leaves `dac_out` unchanged with `integ_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_cyc | input | PER_W (20) | Sample period in clock cycles (0 treated as 1) |
| cmd | input | CMD_W (9) | Signed speed command |
| fb_mag | input | FB_W (8) | Unsigned feedback magnitude |
| fb_dir | input | 1 | Feedback direction, 1 = forward (positive) |
| gain | input | GAIN_W (8) | Gain numerator G; gain = G/255 |
| integ_en | input | 1 | 1 = integrating mode, 0 = proportional only |
| dac_out | output | DAC_W (8) | Offset-binary DAC word, 0x80 = zero drive |
| dac_valid | output | 1 | One-cycle strobe marking a new `dac_out` |

## Verification
The block updates at the clock edge that ends a tick cycle. A new `dac_out` and a high `dac_valid` are therefore due exactly one cycle after the tick: the first one arrives one cycle after reset is released, and each later one arrives `period_cyc` cycles after the one before. The bench drives new operands at the falling edge on which it sees a strobe, so they are stable well before the next tick. It then polls on falling edges until the next strobe and reads the word in that same half cycle. Gap counts, the word's stability between strobes and the immediate post-reset word are checked on falling edges only, clear of the edge on which the registers change.

// File: rtl/spd_pi_pkg.sv
// Package: shared sizing helpers for the sampled PI speed controller.
// Assumes: callers pass positive widths.
package spd_pi_pkg;

    // Width needed to hold a signed difference of a signed CW-bit and an
    // unsigned FW-bit operand without overflow.
    function automatic int err_width(input int cw, input int fw);
        return ((cw > fw + 1) ? cw : fw + 1) + 1;
    endfunction

endpackage

// File: rtl/spd_pi_tick.sv
// Module: programmable sample tick generator.
// Counts down from period-1; tick is high whenever the count is zero, so the
// first tick lands in the first cycle after reset. A period of 0 acts as 1.
// Assumes: period may change at any time; it is picked up at the next reload.
module spd_pi_tick #(
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Reload on tick, otherwise count down toward the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (period == '0) ? '0 : period - PER_W'(1);
        end else begin
            cnt_q <= cnt_q - PER_W'(1);
        end
    end
endmodule

// File: rtl/spd_pi_scale.sv
// Module: error former and gain scaler (combinational).
// Forms err = cmd - (+/-fb_mag), multiplies by the unsigned gain and divides
// by 2^GAIN_W-1 on the magnitude, then restores the sign, so rounding is
// symmetric about zero. ROUND_EN selects round-to-nearest or truncation.
// Assumes: |result| <= |err| since gain <= full scale, so EW bits suffice.
module spd_pi_scale
    import spd_pi_pkg::*;
#(
    parameter int CMD_W    = 9,
    parameter int FB_W     = 8,
    parameter int GAIN_W   = 8,
    parameter bit ROUND_EN = 1'b1,
    localparam int EW      = err_width(CMD_W, FB_W)
) (
    input  logic signed [CMD_W-1:0] cmd,
    input  logic        [FB_W-1:0]  fb_mag,
    input  logic                    fb_dir,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [EW-1:0]    scaled
);
    localparam int PW = EW + GAIN_W + 1;
    localparam logic [PW-1:0] DIV  = PW'((2 ** GAIN_W) - 1);
    localparam logic [PW-1:0] HALF = PW'(((2 ** GAIN_W) - 2) / 2);

    logic signed [EW-1:0] cmd_x, fb_pos, fb_s, err;
    logic signed [PW-1:0] err_x, gain_x, prod;
    logic        [PW-1:0] mag;
    logic        [EW-1:0] mag_q;
    logic                 neg;

    // Sign the feedback from the direction bit and form the error.
    always_comb begin
        cmd_x  = {{(EW-CMD_W){cmd[CMD_W-1]}}, cmd};
        fb_pos = $signed({{(EW-FB_W){1'b0}}, fb_mag});
        fb_s   = fb_dir ? fb_pos : -fb_pos;
        err    = cmd_x - fb_s;
    end

    // Multiply by the gain numerator and split into sign and magnitude.
    always_comb begin
        err_x  = {{(PW-EW){err[EW-1]}}, err};
        gain_x = $signed({{(PW-GAIN_W){1'b0}}, gain});
        prod   = err_x * gain_x;
        neg    = prod[PW-1];
        mag    = neg ? $unsigned(-prod) : $unsigned(prod);
    end

    // Divide the magnitude by full scale, rounding or truncating.
    generate
        if (ROUND_EN) begin : g_round
            assign mag_q = EW'((mag + HALF) / DIV);
        end else begin : g_trunc
            assign mag_q = EW'(mag / DIV);
        end
    endgenerate

    // Reapply the sign.
    assign scaled = neg ? -$signed(mag_q) : $signed(mag_q);
endmodule

// File: rtl/spd_pi_accum.sv
// Module: integrator, limiter and DAC offset stage.
// On tick: sum = scaled + (integ_en ? stored drive : 0), limited to the
// signed DAC_W range, stored, and emitted as offset binary with a strobe.
// Assumes: ACC_W > QW so the unlimited sum cannot overflow, and ACC_W > DAC_W.
module spd_pi_accum #(
    parameter int QW    = 10,
    parameter int ACC_W = 12,
    parameter int DAC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                integ_en,
    input  logic signed [QW-1:0] scaled,
    output logic [DAC_W-1:0]    dac,
    output logic                valid
);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (DAC_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = ACC_W'(-(2 ** (DAC_W-1)));

    logic signed [ACC_W-1:0] acc_q, prev_x, q_x, sum, lim;
    logic        [DAC_W-1:0] word;

    // Build the recursion sum and hold it inside the DAC range.
    always_comb begin
        prev_x = integ_en ? acc_q : '0;
        q_x    = {{(ACC_W-QW){scaled[QW-1]}}, scaled};
        sum    = prev_x + q_x;
        if (sum > HI)      lim = HI;
        else if (sum < LO) lim = LO;
        else               lim = sum;
        word   = {~lim[DAC_W-1], lim[DAC_W-2:0]};
    end

    // Register the limited drive, the DAC word and the strobe on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            dac   <= {1'b1, {(DAC_W-1){1'b0}}};
            valid <= 1'b0;
        end else begin
            valid <= tick;
            if (tick) begin
                acc_q <= lim;
                dac   <= word;
            end
        end
    end
endmodule

// File: rtl/spd_pi_ctrl.sv
// Module: sampled proportional-integral speed controller, top level.
// Ties the tick generator, the error scaler and the accumulator together.
// Assumes: inputs are stable in the tick cycle; reset is synchronous.
module spd_pi_ctrl
    import spd_pi_pkg::*;
#(
    parameter int PER_W    = 20,
    parameter int CMD_W    = 9,
    parameter int FB_W     = 8,
    parameter int GAIN_W   = 8,
    parameter int DAC_W    = 8,
    parameter int ACC_W    = 12,
    parameter bit ROUND_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PER_W-1:0]        period_cyc,
    input  logic signed [CMD_W-1:0] cmd,
    input  logic [FB_W-1:0]         fb_mag,
    input  logic                    fb_dir,
    input  logic [GAIN_W-1:0]       gain,
    input  logic                    integ_en,
    output logic [DAC_W-1:0]        dac_out,
    output logic                    dac_valid
);
    localparam int EW = err_width(CMD_W, FB_W);

    logic                 tick;
    logic signed [EW-1:0] scaled;

    spd_pi_tick #(.PER_W(PER_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period_cyc),
        .tick   (tick)
    );

    spd_pi_scale #(
        .CMD_W(CMD_W), .FB_W(FB_W), .GAIN_W(GAIN_W), .ROUND_EN(ROUND_EN)
    ) u_scale (
        .cmd    (cmd),
        .fb_mag (fb_mag),
        .fb_dir (fb_dir),
        .gain   (gain),
        .scaled (scaled)
    );

    spd_pi_accum #(.QW(EW), .ACC_W(ACC_W), .DAC_W(DAC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .integ_en (integ_en),
        .scaled   (scaled),
        .dac      (dac_out),
        .valid    (dac_valid)
    );
endmodule

// File: rtl/spd_pi_ctrl_chk.sv
// Module: assertion checker for spd_pi_ctrl, attached with bind below.
// Assumes: tick is the internal sample tick of the top module.
module spd_pi_ctrl_chk #(
    parameter int PER_W  = 20,
    parameter int GAIN_W = 8,
    parameter int DAC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [PER_W-1:0]  period_cyc,
    input logic [GAIN_W-1:0] gain,
    input logic              integ_en,
    input logic [DAC_W-1:0]  dac_out,
    input logic              dac_valid
);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_out == MID && !dac_valid));                 // R1
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid && $past(dac_valid)) |-> ($past(period_cyc, 2) <= PER_W'(1))); // R2
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> dac_valid);                                              // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !dac_valid);                                            // R3
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> $stable(dac_out));                                 // R3
    AST_ZERO_GAIN_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gain == '0 && !integ_en) |=> (dac_out == MID));          // R9
    AST_ZERO_GAIN_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && gain == '0 && integ_en) |=> $stable(dac_out));           // R9
endmodule

bind spd_pi_ctrl spd_pi_ctrl_chk #(
    .PER_W(PER_W), .GAIN_W(GAIN_W), .DAC_W(DAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .period_cyc (period_cyc),
    .gain       (gain),
    .integ_en   (integ_en),
    .dac_out    (dac_out),
    .dac_valid  (dac_valid)
);

// File: tb/spd_pi_ctrl_bench.sv
`timescale 1ns/1ps
module spd_pi_ctrl_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [19:0]       period_cyc = 20'd4;
    logic signed [8:0] cmd = '0;
    logic [7:0]        fb_mag = '0;
    logic              fb_dir = 1'b1;
    logic [7:0]        gain = '0;
    logic              integ_en = 1'b0;
    logic [7:0]        dac_out;
    logic              dac_valid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spd_pi_ctrl u_spd_pi_ctrl (
        .clk(clk), .rst_n(rst_n), .period_cyc(period_cyc), .cmd(cmd),
        .fb_mag(fb_mag), .fb_dir(fb_dir), .gain(gain), .integ_en(integ_en),
        .dac_out(dac_out), .dac_valid(dac_valid)
    );

    typedef struct packed {
        logic              integ;
        logic              dir;
        logic signed [8:0] c;
        logic [7:0]        mag;
        logic [7:0]        g;
        logic [7:0]        exp_dac;
        logic [3:0]        req;
    } vec_t;

    // Rows apply in order; integrating rows depend on the row before.
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1,  9'sd100, 8'd0,   8'd255, 8'd228, 4'd6}, // R6 plain proportional
        '{1'b0, 1'b1,  9'sd100, 8'd40,  8'd255, 8'd188, 4'd4}, // R4 forward feedback
        '{1'b0, 1'b0,  9'sd0,   8'd50,  8'd255, 8'd178, 4'd4}, // R4 reverse feedback
        '{1'b0, 1'b1, -9'sd30,  8'd0,   8'd128, 8'd113, 4'd5}, // R5 -3840/255 -> -15
        '{1'b0, 1'b1,  9'sd1,   8'd0,   8'd128, 8'd129, 4'd5}, // R5 128/255 -> 1
        '{1'b0, 1'b1,  9'sd1,   8'd0,   8'd127, 8'd128, 4'd5}, // R5 127/255 -> 0
        '{1'b0, 1'b1, -9'sd1,   8'd0,   8'd128, 8'd127, 4'd5}, // R5 symmetric -1
        '{1'b0, 1'b1,  9'sd200, 8'd0,   8'd255, 8'd255, 4'd8}, // R8 upper limit
        '{1'b0, 1'b1, -9'sd200, 8'd0,   8'd255, 8'd0,   4'd8}, // R8 lower limit
        '{1'b0, 1'b1,  9'sd0,   8'd0,   8'd0,   8'd128, 4'd9}, // R9 zero gain, proportional
        '{1'b1, 1'b1,  9'sd20,  8'd0,   8'd255, 8'd148, 4'd7}, // R7 0+20
        '{1'b1, 1'b1,  9'sd20,  8'd0,   8'd255, 8'd168, 4'd7}, // R7 20+20
        '{1'b1, 1'b1, -9'sd10,  8'd0,   8'd255, 8'd158, 4'd7}, // R7 40-10
        '{1'b1, 1'b1,  9'sd100, 8'd0,   8'd255, 8'd255, 4'd8}, // R8 130 limited to 127
        '{1'b1, 1'b1, -9'sd5,   8'd0,   8'd255, 8'd250, 4'd8}, // R8 no windup: 127-5
        '{1'b1, 1'b1, -9'sd255, 8'd0,   8'd255, 8'd0,   4'd8}, // R8 -133 limited to -128
        '{1'b1, 1'b1,  9'sd10,  8'd0,   8'd255, 8'd10,  4'd7}, // R7 -128+10
        '{1'b0, 1'b1,  9'sd10,  8'd0,   8'd255, 8'd138, 4'd6}, // R6 back to proportional
        '{1'b1, 1'b1,  9'sd0,   8'd100, 8'd51,  8'd118, 4'd4}, // R4 -5100/255=-20, +10
        '{1'b1, 1'b1,  9'sd77,  8'd0,   8'd0,   8'd118, 4'd9}  // R9 zero gain holds
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Poll falling edges until a strobe; returns the number of edges waited.
    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!dac_valid && n < 200);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int n;
        logic [7:0] held;
        repeat (4) @(negedge clk);
        check(dac_out == 8'h80, "R1 reset word", dac_out, 128);
        check(dac_valid == 1'b0, "R1 reset strobe", dac_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_valid == 1'b1, "R2 first tick after reset", dac_valid, 1);
        check(dac_out == 8'h80, "R6 zero inputs", dac_out, 128);

        for (int i = 0; i < NV; i++) begin
            integ_en = VECS[i].integ;
            fb_dir   = VECS[i].dir;
            cmd      = VECS[i].c;
            fb_mag   = VECS[i].mag;
            gain     = VECS[i].g;
            wait_valid(n);
            checks++;
            if (dac_out != VECS[i].exp_dac) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual %0d expected %0d",
                         VECS[i].req, i, dac_out, VECS[i].exp_dac);
            end
        end

        // R2 / R3: period 7 gap, one-cycle strobe, word held between strobes.
        integ_en = 1'b0; cmd = 9'sd3; gain = 8'd255; fb_mag = '0;
        period_cyc = 20'd7;
        wait_valid(n);
        wait_valid(n);
        held = dac_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!dac_valid)
                check(dac_out == held, "R3 word held between strobes", dac_out, held);
        end while (!dac_valid && n < 200);
        check(n == 7, "R2 gap for period 7", n, 7);

        // R2: period 0 behaves as 1 -> strobe every cycle.
        period_cyc = 20'd0;
        wait_valid(n);
        wait_valid(n);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(dac_valid == 1'b1, "R2 period 0 strobe each cycle", dac_valid, 1);
        end

        // R1: reset mid-run clears the stored drive.
        period_cyc = 20'd4;
        integ_en = 1'b1; cmd = 9'sd50; gain = 8'd255;
        wait_valid(n);
        wait_valid(n);
        wait_valid(n);
        check(dac_out == 8'd255, "R8 integrated to limit", dac_out, 255);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dac_out == 8'h80, "R1 reset mid-run word", dac_out, 128);
        check(dac_valid == 1'b0, "R1 reset mid-run strobe", dac_valid, 0);
        cmd = 9'sd5;
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_valid == 1'b1, "R2 first tick after re-reset", dac_valid, 1);
        check(dac_out == 8'd133, "R1 drive cleared by reset", dac_out, 133);
        @(negedge clk);
        check(dac_valid == 1'b0, "R3 strobe lasts one cycle", dac_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule